// File: doc/BRIEF.md
# Tag Permission and Control Unit

This block sits beside a 64-bit in-order core. It applies 4-bit metadata tags that are attached to every 64-bit memory word. It owns the tag control register, which holds one enable bit per check. Supervisor and user software can change only the control bits that machine mode has opened to them, through two enable masks. Each cycle the unit looks at three things: the memory access descriptor issued by the core, the tag of the fetched instruction, and any indirect jump that retires. From these it raises at most one tag exception, carrying a 2-bit cause code.

The unit also executes the two tag instructions. A tag read returns a register's tag as plain data, with a zero tag attached to the result. A tag write sends a register's tag to memory, at a base-plus-offset address. Every output is registered and appears in the cycle after the inputs that caused it.

Top module: `tag_guard`

## Requirements
- R1: After reset the control register, both enable masks and the jump-pending state are zero, and `xcpt_valid`, `res_valid` and `mem_wr_valid` are low.
- R2: Control-register writes are decoded on `csr_addr`.
  - Address 0 replaces the control register outright.
  - Address 3 writes the supervisor mask; address 4 writes the user mask.
  - All three take effect only when `priv` is 2'b11 (machine). At any other privilege they are ignored.
- R3: A write to address 1 while `priv` is 2'b01 (supervisor) or 2'b11 sets the control register to (wdata & supervisor mask) | (old & ~supervisor mask). From user privilege (2'b00) the write is ignored.
- R4: A write to address 2 at any privilege sets the control register to (wdata & user mask) | (old & ~user mask).
- R5: When control bit 0 is set, a load (`acc_op` 0) whose memory tag has bit 0 clear raises cause 2. When control bit 0 is clear, a load never raises it.
- R6: When control bit 1 is set, a store (`acc_op` 1) whose memory tag has bit 1 clear raises cause 3. Only bit 1 of the tag matters for a store.
- R7: When control bit 2 is set, a fetch whose tag has bit 2 set raises cause 0 (breakpoint). When control bit 2 is clear, the fetch raises nothing.
- R8: An indirect jump stores `jump_tag` as the expected target tag and marks a target as pending. The next fetch clears the pending mark. If control bit 3 is set and that fetch's tag bits [1:0] differ from the expected tag, the fetch raises cause 1.
- R9: When several checks fire in one cycle, the reported cause follows this order: breakpoint (0), then control-flow (1), then load (2), then store (3).
- R10: A tag read (`acc_op` 2) returns `rs1_tag`, zero-extended, on `res_data`, and returns `res_tag` = 0.
- R11: A tag write (`acc_op` 3) drives `mem_wr_addr` = `rs1_val` + sign-extended `imm` and `mem_wr_tag` = `rd_tag`.
- R12: Every output reflects the inputs of exactly the previous cycle. With no request, the strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| csr_we | input | 1 | Control register write strobe |
| csr_addr | input | 3 | Write target: 0 ctrl, 1 supervisor merge, 2 user merge, 3 supervisor mask, 4 user mask |
| csr_wdata | input | 8 | Write data |
| acc_valid | input | 1 | Access descriptor valid |
| acc_op | input | 2 | 0 load, 1 store, 2 tag read, 3 tag write |
| acc_mem_tag | input | 4 | Tag of the addressed memory word |
| rs1_val | input | 64 | Source register value |
| rs1_tag | input | 4 | Source register tag |
| rd_tag | input | 4 | Destination register tag (tag write) |
| imm | input | 12 | Signed offset (tag write) |
| fetch_valid | input | 1 | Instruction fetch valid |
| fetch_tag | input | 4 | Tag of the fetched instruction |
| jump_valid | input | 1 | Indirect jump retires |
| jump_tag | input | 2 | Expected tag for the jump target |
| tag_ctrl | output | 8 | Current control register |
| xcpt_valid | output | 1 | Tag exception strobe |
| xcpt_cause | output | 2 | 0 breakpoint, 1 control-flow, 2 load, 3 store |
| res_valid | output | 1 | Tag read result valid |
| res_data | output | 64 | Tag read result value |
| res_tag | output | 4 | Tag read result tag |
| mem_wr_valid | output | 1 | Tag write request valid |
| mem_wr_addr | output | 64 | Tag write address |
| mem_wr_tag | output | 4 | Tag to store |

## Verification
The assertions assume that the request inputs are meaningful only when their valid strobe is high, and that `priv` carries one of the three legal encodings. The bench drives every field to zero whenever its strobe is low and uses only the encodings 00, 01 and 11. The assertions also assume that at most one control write arrives per cycle, which the single write port enforces. Fetch, jump and access inputs may share a cycle, and the bench combines them deliberately to exercise the priority order.

// File: rtl/tag_guard.sv
module tag_guard #(
  parameter int XLEN   = 64,
  parameter int TAG_W  = 4,
  parameter int CTRL_W = 8,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        priv,
  input  logic              csr_we,
  input  logic [2:0]        csr_addr,
  input  logic [CTRL_W-1:0] csr_wdata,
  input  logic              acc_valid,
  input  logic [1:0]        acc_op,
  input  logic [TAG_W-1:0]  acc_mem_tag,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [TAG_W-1:0]  rs1_tag,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [IMM_W-1:0]  imm,
  input  logic              fetch_valid,
  input  logic [TAG_W-1:0]  fetch_tag,
  input  logic              jump_valid,
  input  logic [1:0]        jump_tag,
  output logic [CTRL_W-1:0] tag_ctrl,
  output logic              xcpt_valid,
  output logic [1:0]        xcpt_cause,
  output logic              res_valid,
  output logic [XLEN-1:0]   res_data,
  output logic [TAG_W-1:0]  res_tag,
  output logic              mem_wr_valid,
  output logic [XLEN-1:0]   mem_wr_addr,
  output logic [TAG_W-1:0]  mem_wr_tag
);
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_TR = 2'd2, OP_TW = 2'd3;
  localparam logic [1:0] PRV_M = 2'b11, PRV_S = 2'b01;

  logic [CTRL_W-1:0] ctrl_q, smask_q, umask_q;
  logic              pend_q;
  logic [1:0]        exp_q;

  wire is_m = (priv == PRV_M);
  wire s_ok = is_m || (priv == PRV_S);

  wire bkpt_hit = fetch_valid && fetch_tag[2] && ctrl_q[2];
  wire cfi_hit  = fetch_valid && pend_q && ctrl_q[3] && (fetch_tag[1:0] != exp_q);
  wire ld_hit   = acc_valid && acc_op == OP_LD && ctrl_q[0] && !acc_mem_tag[0];
  wire st_hit   = acc_valid && acc_op == OP_ST && ctrl_q[1] && !acc_mem_tag[1];
  wire any_hit  = bkpt_hit || cfi_hit || ld_hit || st_hit;
  wire [1:0] cause_d = bkpt_hit ? 2'd0 : cfi_hit ? 2'd1 : ld_hit ? 2'd2 : 2'd3;
  wire [XLEN-1:0] imm_x = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

  assign tag_ctrl = ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      smask_q <= '0;
      umask_q <= '0;
    end else if (csr_we) begin
      case (csr_addr)
        3'd0: if (is_m) ctrl_q <= csr_wdata;
        3'd1: if (s_ok) ctrl_q <= (csr_wdata & smask_q) | (ctrl_q & ~smask_q);
        3'd2: ctrl_q <= (csr_wdata & umask_q) | (ctrl_q & ~umask_q);
        3'd3: if (is_m) smask_q <= csr_wdata;
        3'd4: if (is_m) umask_q <= csr_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      exp_q  <= '0;
    end else if (jump_valid) begin
      pend_q <= 1'b1;
      exp_q  <= jump_tag;
    end else if (fetch_valid) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xcpt_valid   <= 1'b0;
      xcpt_cause   <= '0;
      res_valid    <= 1'b0;
      res_data     <= '0;
      res_tag      <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_tag   <= '0;
    end else begin
      xcpt_valid   <= any_hit;
      xcpt_cause   <= any_hit ? cause_d : 2'd0;
      res_valid    <= acc_valid && acc_op == OP_TR;
      res_data     <= (acc_valid && acc_op == OP_TR) ? {{(XLEN-TAG_W){1'b0}}, rs1_tag} : '0;
      res_tag      <= '0;
      mem_wr_valid <= acc_valid && acc_op == OP_TW;
      mem_wr_addr  <= (acc_valid && acc_op == OP_TW) ? rs1_val + imm_x : '0;
      mem_wr_tag   <= (acc_valid && acc_op == OP_TW) ? rd_tag : '0;
    end
  end

  assert_mask_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !is_m && (csr_addr == 3'd3 || csr_addr == 3'd4)) |=> ($stable(smask_q) && $stable(umask_q)));

  assert_user_no_smerge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && priv == 2'b00 && (csr_addr == 3'd1 || csr_addr == 3'd0)) |=> $stable(tag_ctrl));

  assert_bkpt_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_tag[2] && tag_ctrl[2]) |=> (xcpt_valid && xcpt_cause == 2'd0));

  assert_cause0_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xcpt_valid && xcpt_cause == 2'd0) |-> $past(fetch_valid && fetch_tag[2]));

  assert_load_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xcpt_valid && xcpt_cause == 2'd2) |-> $past(tag_ctrl[0] && acc_valid && acc_op == OP_LD));

  assert_tagread_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == OP_TR) |=> (res_valid && res_tag == '0 && res_data[TAG_W-1:0] == $past(rs1_tag)));

  assert_tagwrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_op == OP_TW) |=> (mem_wr_valid && mem_wr_tag == $past(rd_tag)));

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !fetch_valid) |=> (!xcpt_valid && !res_valid && !mem_wr_valid));
endmodule

// File: tb/tag_guard_tb.sv
module tag_guard_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv = '0;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [7:0]  csr_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_op = '0;
  logic [3:0]  acc_mem_tag = '0;
  logic [63:0] rs1_val = '0;
  logic [3:0]  rs1_tag = '0, rd_tag = '0;
  logic [11:0] imm = '0;
  logic        fetch_valid = 1'b0;
  logic [3:0]  fetch_tag = '0;
  logic        jump_valid = 1'b0;
  logic [1:0]  jump_tag = '0;
  logic [7:0]  tag_ctrl;
  logic        xcpt_valid, res_valid, mem_wr_valid;
  logic [1:0]  xcpt_cause;
  logic [63:0] res_data, mem_wr_addr;
  logic [3:0]  res_tag, mem_wr_tag;

  tag_guard dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string       req;
    logic [7:0]  ctrl;
    logic        xv;
    logic [1:0]  cause;
    logic        rv;
    logic [63:0] rdata;
    logic        wv;
    logic [63:0] waddr;
    logic [3:0]  wtag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errors = 0;
  logic [7:0] m_ctrl = '0, m_sm = '0, m_um = '0;
  logic m_pend = 1'b0;
  logic [1:0] m_exp = '0;

  task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp(e.req, "ctrl", {56'd0, tag_ctrl}, {56'd0, e.ctrl});
      cmp(e.req, "xcpt_valid", {63'd0, xcpt_valid}, {63'd0, e.xv});
      if (e.xv) cmp(e.req, "xcpt_cause", {62'd0, xcpt_cause}, {62'd0, e.cause});
      cmp(e.req, "res_valid", {63'd0, res_valid}, {63'd0, e.rv});
      if (e.rv) begin
        cmp(e.req, "res_data", res_data, e.rdata);
        cmp(e.req, "res_tag", {60'd0, res_tag}, 64'd0);
      end
      cmp(e.req, "mem_wr_valid", {63'd0, mem_wr_valid}, {63'd0, e.wv});
      if (e.wv) begin
        cmp(e.req, "mem_wr_addr", mem_wr_addr, e.waddr);
        cmp(e.req, "mem_wr_tag", {60'd0, mem_wr_tag}, {60'd0, e.wtag});
      end
    end
  end

  task automatic step(string req, logic [1:0] pv, logic we, logic [2:0] ad, logic [7:0] wd,
                      logic av, logic [1:0] op, logic [3:0] mt, logic [63:0] r1, logic [3:0] r1t,
                      logic [3:0] rdt, logic [11:0] im, logic fv, logic [3:0] ft,
                      logic jv, logic [1:0] jt);
    exp_t e;
    logic bk, cf, ld, st;
    @(negedge clk);
    priv = pv; csr_we = we; csr_addr = ad; csr_wdata = wd;
    acc_valid = av; acc_op = op; acc_mem_tag = mt; rs1_val = r1; rs1_tag = r1t;
    rd_tag = rdt; imm = im; fetch_valid = fv; fetch_tag = ft; jump_valid = jv; jump_tag = jt;
    bk = fv && ft[2] && m_ctrl[2];
    cf = fv && m_pend && m_ctrl[3] && (ft[1:0] != m_exp);
    ld = av && op == 2'd0 && m_ctrl[0] && !mt[0];
    st = av && op == 2'd1 && m_ctrl[1] && !mt[1];
    e.req = req;
    e.xv = bk || cf || ld || st;
    e.cause = bk ? 2'd0 : cf ? 2'd1 : ld ? 2'd2 : 2'd3;
    e.rv = av && op == 2'd2;
    e.rdata = {60'd0, r1t};
    e.wv = av && op == 2'd3;
    e.waddr = r1 + {{52{im[11]}}, im};
    e.wtag = rdt;
    if (we) begin
      if (ad == 3'd0 && pv == 2'b11) m_ctrl = wd;
      else if (ad == 3'd1 && pv != 2'b00) m_ctrl = (wd & m_sm) | (m_ctrl & ~m_sm);
      else if (ad == 3'd2) m_ctrl = (wd & m_um) | (m_ctrl & ~m_um);
      else if (ad == 3'd3 && pv == 2'b11) m_sm = wd;
      else if (ad == 3'd4 && pv == 2'b11) m_um = wd;
    end
    if (jv) begin m_pend = 1'b1; m_exp = jt; end
    else if (fv) m_pend = 1'b0;
    e.ctrl = m_ctrl;
    sb.push_back(e);
  endtask

  task automatic csr(string req, logic [1:0] pv, logic [2:0] ad, logic [7:0] wd);
    step(req, pv, 1'b1, ad, wd, 1'b0, 2'd0, 4'd0, 64'd0, 4'd0, 4'd0, 12'd0, 1'b0, 4'd0, 1'b0, 2'd0);
  endtask
  task automatic acc(string req, logic [1:0] op, logic [3:0] mt, logic [63:0] r1,
                     logic [3:0] r1t, logic [3:0] rdt, logic [11:0] im);
    step(req, 2'b11, 1'b0, 3'd0, 8'd0, 1'b1, op, mt, r1, r1t, rdt, im, 1'b0, 4'd0, 1'b0, 2'd0);
  endtask
  task automatic fet(string req, logic fv, logic [3:0] ft, logic jv, logic [1:0] jt);
    step(req, 2'b11, 1'b0, 3'd0, 8'd0, 1'b0, 2'd0, 4'd0, 64'd0, 4'd0, 4'd0, 12'd0, fv, ft, jv, jt);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", "ctrl at reset", {56'd0, tag_ctrl}, 64'd0);
    cmp("R1", "strobes at reset", {61'd0, xcpt_valid, res_valid, mem_wr_valid}, 64'd0);
    rst_n = 1'b1;
    // R1: checks disabled after reset
    acc("R1 R5", 2'd0, 4'h0, 64'd0, 4'd0, 4'd0, 12'd0);
    fet("R1 R7", 1'b1, 4'h4, 1'b0, 2'd0);
    // R2: mask and ctrl writes need machine privilege
    csr("R2", 2'b01, 3'd3, 8'hFF);
    csr("R2", 2'b01, 3'd1, 8'hFF);
    csr("R2", 2'b01, 3'd0, 8'hFF);
    // R3: supervisor merge
    csr("R3", 2'b11, 3'd3, 8'h03);
    csr("R3", 2'b01, 3'd1, 8'hFF);
    csr("R3", 2'b00, 3'd1, 8'h00);
    // R4: user merge
    csr("R4", 2'b00, 3'd2, 8'hFF);
    csr("R4", 2'b11, 3'd4, 8'h0C);
    csr("R4", 2'b00, 3'd2, 8'h04);
    csr("R2", 2'b00, 3'd4, 8'hFF);
    csr("R4", 2'b00, 3'd2, 8'hF8);
    csr("R2", 2'b11, 3'd0, 8'h0F);
    // R5 / R6
    acc("R5", 2'd0, 4'h1, 64'd0, 4'd0, 4'd0, 12'd0);
    acc("R5", 2'd0, 4'h2, 64'd0, 4'd0, 4'd0, 12'd0);
    acc("R6", 2'd1, 4'h2, 64'd0, 4'd0, 4'd0, 12'd0);
    acc("R6", 2'd1, 4'h1, 64'd0, 4'd0, 4'd0, 12'd0);
    // R7
    fet("R7", 1'b1, 4'h4, 1'b0, 2'd0);
    fet("R7", 1'b1, 4'h3, 1'b0, 2'd0);
    // R8
    fet("R8", 1'b0, 4'h0, 1'b1, 2'd1);
    fet("R8", 1'b1, 4'h1, 1'b0, 2'd0);
    fet("R8", 1'b0, 4'h0, 1'b1, 2'd1);
    fet("R8", 1'b1, 4'h2, 1'b0, 2'd0);
    fet("R8", 1'b1, 4'h2, 1'b0, 2'd0);
    // R9: simultaneous hits
    fet("R9", 1'b0, 4'h0, 1'b1, 2'd1);
    step("R9", 2'b11, 1'b0, 3'd0, 8'd0, 1'b1, 2'd0, 4'h0, 64'd0, 4'd0, 4'd0, 12'd0, 1'b1, 4'h6, 1'b0, 2'd0);
    fet("R9", 1'b0, 4'h0, 1'b1, 2'd1);
    step("R9", 2'b11, 1'b0, 3'd0, 8'd0, 1'b1, 2'd1, 4'h0, 64'd0, 4'd0, 4'd0, 12'd0, 1'b1, 4'h2, 1'b0, 2'd0);
    step("R9", 2'b11, 1'b0, 3'd0, 8'd0, 1'b1, 2'd0, 4'h0, 64'd0, 4'd0, 4'd0, 12'd0, 1'b1, 4'h1, 1'b0, 2'd0);
    // R10 / R11 / R12
    acc("R10", 2'd2, 4'h0, 64'hDEAD, 4'hA, 4'd0, 12'd0);
    fet("R12", 1'b0, 4'h0, 1'b0, 2'd0);
    acc("R11", 2'd3, 4'h0, 64'h1000, 4'h0, 4'h6, 12'hFF8);
    acc("R11", 2'd3, 4'h0, 64'h2000, 4'h0, 4'h9, 12'h010);
    fet("R12", 1'b0, 4'h0, 1'b0, 2'd0);
    // disabled checks again
    csr("R5", 2'b11, 3'd0, 8'h00);
    acc("R5", 2'd0, 4'h0, 64'd0, 4'd0, 4'd0, 12'd0);
    fet("R8", 1'b0, 4'h0, 1'b1, 2'd2);
    fet("R8", 1'b1, 4'h1, 1'b0, 2'd0);
    fet("R12", 1'b0, 4'h0, 1'b0, 2'd0);
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule